// File: doc/BRIEF.md
# Dual-Product Add/Subtract Multiplier Slice

This block is an arithmetic slice for datapaths built from repeated tiles. It forms two products from two operand pairs and returns their sum or difference. A build option doubles the slice: a second product pair has its own add/subtract stage, and a final adder combines the two partial results into one wider word. Operands are two's complement or unsigned, chosen at run time, and each product pair chooses addition or subtraction at run time.

There are three optional register stages: operand capture, product hold, and result. Each is switched in or out at build time. Each stage that is switched in takes one of four shared clock-enable lines and one of four shared synchronous clear lines, chosen by parameter. The operand stage can load each operand from its own parallel port or from a chain. Operand 0 takes the chain input, and each later operand takes the stored value of the one before it. The last stored operand is driven out so that several slices can be linked into a longer delay line. The sign and add/subtract controls pass through the same stages as the data, so they always apply to the operands they were presented with.

Top module: `mul2_addsub_slice`

## Requirements
- R1: In the two-product build, `result` is the low m+n+1 bits of A0·B0 + A1·B1 when `op_sub[0]` is 0, and of A0·B0 − A1·B1 when it is 1 (m = `A_W`, n = `B_W`).
- R2: When `op_signed` is 1, every operand is read as two's complement. When it is 0, every operand is read as unsigned.
- R3: In the four-product build (`FOUR_PROD`=1), `result` is the low m+n+2 bits of (A0·B0 ± A1·B1) + (A2·B2 ± A3·B3). `op_sub[0]` selects the sign for the first pair and `op_sub[1]` for the second.
- R4: The delay from operands to `result` is `IN_REG`+`PIPE_REG`+`OUT_REG` clock cycles. The `op_signed` and `op_sub` values that arrive with the operands are the ones applied to them.
- R5: A stage that is switched in loads new data only on a clock edge where its selected line `ce[sel]` is 1. On any other edge it keeps its contents.
- R6: A stage that is switched in clears to zero on a clock edge where its selected line `srst[sel]` is 1. The clear wins over the enable.
- R7: When `a_chain_sel` is 1, the operand stage loads A0 from `a_chain_in` and loads each later Ai from the stored Ai−1. `a_chain_out` always shows the stored value of the last A operand. The B chain behaves the same way with `b_chain_sel`, `b_chain_in` and `b_chain_out`.
- R8: While `rst_n` is 0, every register stage is zero without waiting for a clock edge. `result` and both chain outputs then read zero whenever a register stage lies on their path.
- R9: Clock-enable and clear lines that a stage does not select have no effect on that stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 4 | Shared clock-enable lines |
| srst | input | 4 | Shared synchronous clear lines |
| a_par | input | NPROD×A_W | Parallel multiplicands, one per product |
| b_par | input | NPROD×B_W | Parallel multipliers, one per product |
| a_chain_sel | input | 1 | 1: A operands load from the chain |
| b_chain_sel | input | 1 | 1: B operands load from the chain |
| a_chain_in | input | A_W | A chain input from the previous slice |
| b_chain_in | input | B_W | B chain input from the previous slice |
| a_chain_out | output | A_W | Stored last A operand, for the next slice |
| b_chain_out | output | B_W | Stored last B operand, for the next slice |
| op_signed | input | 1 | 1: two's complement, 0: unsigned |
| op_sub | input | NPAIR | Per pair: 0 adds, 1 subtracts |
| result | output | R_W | m+n+1 bits (two-product) or m+n+2 bits (four-product) |

## Verification
The bench builds eight two-product slices with 9-bit operands, one for each on/off setting of the three register stages. All eight share the same random signed, unsigned and extreme operands, so every latency from 0 to 3 is compared against a single history of expected sums and differences. A ninth slice is the four-product build with every stage switched in and a different enable and clear line assigned to each stage. It is driven through phases of random enables, random clears, chain loading, and toggling of the lines it does not select. This brings stalls, clear priority, the shift chain and the final widened sum within reach.

// File: rtl/slice_pkg.sv
`timescale 1ns/1ps
package slice_pkg;
  localparam int unsigned LINES = 4;
  typedef enum logic {LOAD_PAR = 1'b0, LOAD_CHAIN = 1'b1} load_src_e;
endpackage

// File: rtl/dsp_opt_reg.sv
`timescale 1ns/1ps
module dsp_opt_reg
  import slice_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned EN      = 1,
  parameter int unsigned CE_SEL  = 0,
  parameter int unsigned RST_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] ce,
  input  logic [LINES-1:0] srst,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q
);
  generate
    if (EN != 0) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nx;

      always_comb begin
        q_nx = q_r;
        if (srst[RST_SEL]) q_nx = '0;
        else if (ce[CE_SEL]) q_nx = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nx;
      end

      assign q = q_r;

      // R6: the selected clear empties the stage, enable or not
      assert_sync_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        srst[RST_SEL] |=> (q_r == '0));
      // R5: no enable, no clear -> contents held
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst[RST_SEL] && !ce[CE_SEL]) |=> $stable(q_r));
      // R5: enabled edge captures the presented data
      assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst[RST_SEL] && ce[CE_SEL]) |=> (q_r == $past(d)));
    end else begin : g_wire
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, ce, srst};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dsp_mult.sv
`timescale 1ns/1ps
module dsp_mult #(
  parameter int unsigned A_W = 9,
  parameter int unsigned B_W = 9
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  input  logic               sgn,
  output logic [A_W+B_W-1:0] p
);
  localparam int unsigned P_W = A_W + B_W;
  logic [P_W-1:0] a_x;
  logic [P_W-1:0] b_x;

  assign a_x = {{B_W{sgn & a[A_W-1]}}, a};
  assign b_x = {{A_W{sgn & b[B_W-1]}}, b};
  assign p   = a_x * b_x;
endmodule

// File: rtl/dsp_addsub.sv
`timescale 1ns/1ps
module dsp_addsub #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         x_sgn,
  input  logic         y_sgn,
  input  logic         sub,
  output logic [W:0]   s
);
  logic [W:0] xe;
  logic [W:0] ye;

  assign xe = {x_sgn & x[W-1], x};
  assign ye = {y_sgn & y[W-1], y};
  assign s  = sub ? (xe - ye) : (xe + ye);
endmodule

// File: rtl/mul2_addsub_slice.sv
`timescale 1ns/1ps
module mul2_addsub_slice
  import slice_pkg::*;
#(
  parameter int unsigned A_W       = 9,
  parameter int unsigned B_W       = 9,
  parameter int unsigned FOUR_PROD = 0,
  parameter int unsigned IN_REG    = 1,
  parameter int unsigned PIPE_REG  = 1,
  parameter int unsigned OUT_REG   = 1,
  parameter int unsigned IN_CE     = 0,
  parameter int unsigned IN_RST    = 0,
  parameter int unsigned PIPE_CE   = 0,
  parameter int unsigned PIPE_RST  = 0,
  parameter int unsigned OUT_CE    = 0,
  parameter int unsigned OUT_RST   = 0,
  localparam int unsigned NPROD    = (FOUR_PROD != 0) ? 4 : 2,
  localparam int unsigned NPAIR    = NPROD / 2,
  localparam int unsigned P_W      = A_W + B_W,
  localparam int unsigned S_W      = P_W + 1,
  localparam int unsigned R_W      = (FOUR_PROD != 0) ? P_W + 2 : P_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LINES-1:0]          ce,
  input  logic [LINES-1:0]          srst,
  input  logic [NPROD-1:0][A_W-1:0] a_par,
  input  logic [NPROD-1:0][B_W-1:0] b_par,
  input  logic                      a_chain_sel,
  input  logic                      b_chain_sel,
  input  logic [A_W-1:0]            a_chain_in,
  input  logic [B_W-1:0]            b_chain_in,
  output logic [A_W-1:0]            a_chain_out,
  output logic [B_W-1:0]            b_chain_out,
  input  logic                      op_signed,
  input  logic [NPAIR-1:0]          op_sub,
  output logic [R_W-1:0]            result
);
  load_src_e      a_src;
  load_src_e      b_src;
  logic [A_W-1:0] a_d    [NPROD];
  logic [A_W-1:0] a_q    [NPROD];
  logic [B_W-1:0] b_d    [NPROD];
  logic [B_W-1:0] b_q    [NPROD];
  logic [P_W-1:0] prod   [NPROD];
  logic [P_W-1:0] prod_q [NPROD];
  logic [S_W-1:0] psum   [NPAIR];
  logic [NPAIR:0] ctl_d, ctl1, ctl2;
  logic           sg1, sg2;
  logic [NPAIR-1:0] sub2;
  logic [R_W-1:0] total;

  assign a_src = load_src_e'(a_chain_sel);
  assign b_src = load_src_e'(b_chain_sel);
  assign ctl_d = {op_signed, op_sub};

  // Control bits travel with the data through stages 1 and 2
  dsp_opt_reg #(.W(NPAIR+1), .EN(IN_REG), .CE_SEL(IN_CE), .RST_SEL(IN_RST)) u_ctl_in (
    .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst), .d(ctl_d), .q(ctl1));
  dsp_opt_reg #(.W(NPAIR+1), .EN(PIPE_REG), .CE_SEL(PIPE_CE), .RST_SEL(PIPE_RST)) u_ctl_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst), .d(ctl1), .q(ctl2));

  assign sg1  = ctl1[NPAIR];
  assign sg2  = ctl2[NPAIR];
  assign sub2 = ctl2[NPAIR-1:0];

  generate
    for (genvar i = 0; i < NPROD; i++) begin : g_lane
      if (i == 0) begin : g_head
        assign a_d[i] = (a_src == LOAD_CHAIN) ? a_chain_in : a_par[i];
        assign b_d[i] = (b_src == LOAD_CHAIN) ? b_chain_in : b_par[i];
      end else begin : g_link
        assign a_d[i] = (a_src == LOAD_CHAIN) ? a_q[i-1] : a_par[i];
        assign b_d[i] = (b_src == LOAD_CHAIN) ? b_q[i-1] : b_par[i];
      end

      dsp_opt_reg #(.W(A_W), .EN(IN_REG), .CE_SEL(IN_CE), .RST_SEL(IN_RST)) u_a_reg (
        .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst), .d(a_d[i]), .q(a_q[i]));
      dsp_opt_reg #(.W(B_W), .EN(IN_REG), .CE_SEL(IN_CE), .RST_SEL(IN_RST)) u_b_reg (
        .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst), .d(b_d[i]), .q(b_q[i]));

      dsp_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
        .a(a_q[i]), .b(b_q[i]), .sgn(sg1), .p(prod[i]));

      dsp_opt_reg #(.W(P_W), .EN(PIPE_REG), .CE_SEL(PIPE_CE), .RST_SEL(PIPE_RST)) u_p_reg (
        .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst), .d(prod[i]), .q(prod_q[i]));
    end

    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
      dsp_addsub #(.W(P_W)) u_pair (
        .x(prod_q[2*j]), .y(prod_q[2*j+1]), .x_sgn(sg2), .y_sgn(sg2),
        .sub(sub2[j]), .s(psum[j]));
    end

    if (FOUR_PROD != 0) begin : g_four
      // A partial result is signed unless it is an unsigned sum
      dsp_addsub #(.W(S_W)) u_final (
        .x(psum[0]), .y(psum[1]), .x_sgn(sg2 | sub2[0]), .y_sgn(sg2 | sub2[1]),
        .sub(1'b0), .s(total));
    end else begin : g_two
      assign total = psum[0];
    end
  endgenerate

  dsp_opt_reg #(.W(R_W), .EN(OUT_REG), .CE_SEL(OUT_CE), .RST_SEL(OUT_RST)) u_out_reg (
    .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst), .d(total), .q(result));

  assign a_chain_out = a_q[NPROD-1];
  assign b_chain_out = b_q[NPROD-1];

  // R1: undoing the first pair's operation recovers the first product
  logic [S_W-1:0] chk_x, chk_y;
  assign chk_x = {sg2 & prod_q[0][P_W-1], prod_q[0]};
  assign chk_y = {sg2 & prod_q[1][P_W-1], prod_q[1]};
  assert_pair_inverse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((sub2[0] ? (psum[0] + chk_y) : (psum[0] - chk_y)) == chk_x));

  generate
    if (IN_REG != 0) begin : g_chain_chk
      // R7: operand 0 takes the chain input on a chained load
      assert_chain_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_chain_sel && ce[IN_CE] && !srst[IN_RST]) |=> (a_q[0] == $past(a_chain_in)));
      // R7: operand 1 takes the previous stored operand 0
      assert_chain_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_chain_sel && ce[IN_CE] && !srst[IN_RST]) |=> (b_q[1] == $past(b_q[0])));
    end
  endgenerate
endmodule

// File: tb/mul2_addsub_slice_tb_top.sv
`timescale 1ns/1ps
module mul2_addsub_slice_tb_top;
  localparam int AW  = 9;
  localparam int BW  = 9;
  localparam int CRW = 19;
  localparam int SRW = 20;
  localparam longint CMASK = (64'sd1 <<< CRW) - 1;
  localparam longint SMASK = (64'sd1 <<< SRW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0][AW-1:0] tb_a = '0;
  logic [3:0][BW-1:0] tb_b = '0;
  logic               tb_sg = 1'b0;
  logic [1:0]         tb_sub = '0;
  logic               a_sel = 1'b0, b_sel = 1'b0;
  logic [AW-1:0]      a_si = '0;
  logic [BW-1:0]      b_si = '0;
  logic [3:0]         ce_s = 4'b1110, srst_s = 4'b0000;

  logic [SRW-1:0] s_res;
  logic [AW-1:0]  s_aso;
  logic [BW-1:0]  s_bso;
  logic [CRW-1:0] c_res [8];
  logic [AW-1:0]  c_aso [8];
  logic [BW-1:0]  c_bso [8];

  int n_chk = 0;
  int n_err = 0;
  int jc = 0;
  bit done = 0;
  logic [CRW-1:0] hist [0:8191];

  // Four-product slice, distinct lines per stage: in ce1/rst2, pipe ce2/rst3, out ce3/rst1
  mul2_addsub_slice #(.A_W(AW), .B_W(BW), .FOUR_PROD(1), .IN_REG(1), .PIPE_REG(1), .OUT_REG(1),
    .IN_CE(1), .IN_RST(2), .PIPE_CE(2), .PIPE_RST(3), .OUT_CE(3), .OUT_RST(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce_s), .srst(srst_s), .a_par(tb_a), .b_par(tb_b),
    .a_chain_sel(a_sel), .b_chain_sel(b_sel), .a_chain_in(a_si), .b_chain_in(b_si),
    .a_chain_out(s_aso), .b_chain_out(s_bso), .op_signed(tb_sg), .op_sub(tb_sub),
    .result(s_res));

  // Two-product slices, one per register on/off combination
  for (genvar k = 0; k < 8; k++) begin : g_combo
    mul2_addsub_slice #(.A_W(AW), .B_W(BW), .FOUR_PROD(0),
      .IN_REG(k % 2), .PIPE_REG((k / 2) % 2), .OUT_REG((k / 4) % 2)) u_combo (
      .clk(clk), .rst_n(rst_n), .ce(4'b1111), .srst(4'b0000),
      .a_par(tb_a[1:0]), .b_par(tb_b[1:0]),
      .a_chain_sel(1'b0), .b_chain_sel(1'b0), .a_chain_in('0), .b_chain_in('0),
      .a_chain_out(c_aso[k]), .b_chain_out(c_bso[k]), .op_signed(tb_sg),
      .op_sub(tb_sub[0:0]), .result(c_res[k]));
  end

  function automatic longint opval(input logic [8:0] v, input logic sg);
    return sg ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic longint prodv(input logic [8:0] a, input logic [8:0] b, input logic sg);
    return opval(a, sg) * opval(b, sg);
  endfunction

  function automatic logic [8:0] pick();
    case ($urandom % 6)
      0: return 9'h000;
      1: return 9'h1FF;
      2: return 9'h100;
      default: return 9'($urandom);
    endcase
  endfunction

  // Behavioural model of the four-product slice
  logic [AW-1:0] ma [4];
  logic [BW-1:0] mb [4];
  logic          msg;
  logic [1:0]    mas1, mas2;
  longint        mp [4];
  longint        mres;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin ma[i] = '0; mb[i] = '0; mp[i] = 0; end
      msg = 0; mas1 = 0; mas2 = 0; mres = 0;
    end else begin
      if (srst_s[1]) mres = 0;
      else if (ce_s[3])
        mres = (mas2[0] ? mp[0] - mp[1] : mp[0] + mp[1]) + (mas2[1] ? mp[2] - mp[3] : mp[2] + mp[3]);
      if (srst_s[3]) begin
        for (int i = 0; i < 4; i++) mp[i] = 0;
        mas2 = 0;
      end else if (ce_s[2]) begin
        for (int i = 0; i < 4; i++) mp[i] = prodv(ma[i], mb[i], msg);
        mas2 = mas1;
      end
      if (srst_s[2]) begin
        for (int i = 0; i < 4; i++) begin ma[i] = '0; mb[i] = '0; end
        msg = 0; mas1 = 0;
      end else if (ce_s[1]) begin
        for (int i = 3; i >= 0; i--) begin
          ma[i] = a_sel ? ((i == 0) ? a_si : ma[i-1]) : tb_a[i];
          mb[i] = b_sel ? ((i == 0) ? b_si : mb[i-1]) : tb_b[i];
        end
        msg = tb_sg; mas1 = tb_sub;
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input int mode);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin tb_a[i] = pick(); tb_b[i] = pick(); end
    tb_sg = 1'($urandom); tb_sub = 2'($urandom);
    a_sel = 0; b_sel = 0; a_si = pick(); b_si = pick();
    ce_s = 4'b1110; srst_s = 4'b0000;
    case (mode)
      1: ce_s[3:1] = 3'($urandom);
      2: for (int i = 1; i < 4; i++) srst_s[i] = (($urandom % 5) == 0);
      3: begin
        a_sel = (($urandom % 4) != 0); b_sel = (($urandom % 4) != 0);
        ce_s[1] = (($urandom % 4) != 0);
      end
      4: begin ce_s[0] = 1'($urandom); srst_s[0] = 1'($urandom); end
      default: ;
    endcase
    hist[jc] = CRW'((tb_sub[0] ? prodv(tb_a[0], tb_b[0], tb_sg) - prodv(tb_a[1], tb_b[1], tb_sg)
                               : prodv(tb_a[0], tb_b[0], tb_sg) + prodv(tb_a[1], tb_b[1], tb_sg)) & CMASK);
    #1.5;
    for (int k = 0; k < 8; k++) begin
      int lat;
      lat = (k % 2) + ((k / 2) % 2) + ((k / 4) % 2);
      check($sformatf("R1 R2 R4 combo%0d", k), longint'(c_res[k]),
            (jc >= lat) ? longint'(hist[jc - lat]) : 0);
    end
    check({tag, " R3 result"}, longint'(s_res), mres & SMASK);
    check({tag, " a_chain_out"}, longint'(s_aso), longint'(ma[3]));
    check({tag, " b_chain_out"}, longint'(s_bso), longint'(mb[3]));
    jc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin tb_a[i] = 9'h1FF; tb_b[i] = 9'h155; end
    tb_sg = 1; tb_sub = 2'b11; ce_s = 4'b1111; srst_s = '0;
    rst_n = 1'b0;
    #1;
    for (int k = 1; k < 8; k++) check($sformatf("R8 combo%0d", k), longint'(c_res[k]), 0);
    check("R8 result", longint'(s_res), 0);
    check("R8 a_chain_out", longint'(s_aso), 0);
    check("R8 b_chain_out", longint'(s_bso), 0);
    tb_a = '0; tb_b = '0; tb_sg = 0; tb_sub = '0; ce_s = 4'b1110;
    @(negedge clk);
    rst_n = 1'b1;
    jc = 0;
  endtask

  initial begin
    do_reset();
    repeat (300) step("R4", 0);
    repeat (300) step("R5", 1);
    do_reset();
    repeat (300) step("R6", 2);
    repeat (300) step("R7", 3);
    repeat (300) step("R9", 4);
    do_reset();
    repeat (50) step("R4", 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule